// File: doc/BRIEF.md
# PLL Bring-up Sequencer

This block runs the clock-tree start-up for a set of five PLLs once the frequency of the reference oscillator is known. It is given a 3-bit reference-select code, a chip-family flag, an errata-silicon flag and a flag that says whether the accelerator PLL is fitted. From these it programs the system clock registers: the select code itself, a reference pre-divider (÷1 or ÷2) and, on the newer family, the input divider of the secondary PLL. It also derives the index of the row of the parameter table that the caller must present on `pll_cfg`.

Each PLL is then stepped through three phases: an unlock mode, programming and lock. The sequencer issues masked read-modify-write commands (address, mask, data) over a valid/ready handshake, one at a time. It polls the 2-bit status of each PLL, and every poll has a programmable timeout. The processor PLL is put into low-power bypass first. The core, peripheral, peripheral-2 and (when fitted) accelerator PLLs are programmed next. The processor PLL is programmed and locked last. A poll that times out stops the sequence and leaves a sticky error that names the PLL that failed.

Top module: `pll_bringup_seq`

## Requirements
- R1: With a select code above 2, the pre-divider field (bits 7:6 of the clock-control register, address SYS_BASE+1) is written with 2 and `tbl_idx` is the code shifted right by one. Otherwise the field is written with 1 and `tbl_idx` equals the code. The code itself goes into bits 2:0 of address SYS_BASE.
- R2: Bit 8 of the clock-control register is cleared only when `newer_family` is 1 and the select code is not 1. In every other case that bit keeps its value.
- R3: The first mode write goes to the processor PLL (id 0, register base 0) with low-power bypass (5), and its idle poll completes before any other PLL is touched. The command that writes lock mode (7) to the processor PLL is the last command of a run.
- R4: Lock writes occur in the order core (id 1), peripheral (id 2), peripheral-2 (id 3), accelerator (id 4), processor (id 0). When `has_accel` is 0, the accelerator is skipped and no command addresses its registers.
- R5: PLL p has registers at 4p+0 (mode in bits 2:0, frequency-select in bits 7:4), at 4p+1 (11-bit multiplier in bits 18:8, 7-bit divider in bits 6:0) and at 4p+2 (5-bit post-divider in bits 4:0). After a successful run these registers hold the `pll_cfg` values and mode 7. Each `pll_cfg` slice is {fsel[3:0], m2[4:0], mult[10:0], ndiv[6:0]}, with PLL p at bits 27p+26:27p.
- R6: With `errata_si` set, each post-divider is written twice: first with its value plus 1 (modulo 32), then with its value. Without the flag it is written once.
- R7: The peripheral PLL counts as locked only when its status equals 2, and as idle when its status is 0. The other PLLs count as locked when status bit 0 is 1, and as idle when it is 0. Status of PLL p is `pll_stat[2p+1:2p]`.
- R8: A poll that has not matched after `poll_limit`+1 samples ends the run. `err` is set with `done`, `err_pll` names the PLL, and no further command is issued. `err` holds until the next accepted start.
- R9: A status that matches on the last allowed sample of a poll counts as success, not as a timeout.
- R10: `cmd_valid` with its address, mask and data stays stable until `cmd_ready` is high, and only one command is outstanding at a time.
- R11: A start while busy is ignored. `done` rises when a run ends and stays high, with `busy` low, until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (ignored while busy) |
| sel_code | input | 3 | Reference-select code |
| newer_family | input | 1 | Newer chip family: enables the bit-8 clear |
| errata_si | input | 1 | Errata silicon: double post-divider writes |
| has_accel | input | 1 | Accelerator PLL is fitted |
| poll_limit | input | TMO_W | Poll timeout count |
| pll_cfg | input | NPLL*27 | Parameters of the selected table row, per PLL |
| pll_stat | input | 2*NPLL | Status of each PLL |
| tbl_idx | output | 3 | Table row the caller must present |
| cmd_valid | output | 1 | Command valid |
| cmd_ready | input | 1 | Command accepted |
| cmd_addr | output | ADDR_W | Register address |
| cmd_mask | output | 32 | Bits to modify |
| cmd_data | output | 32 | New value of the masked bits |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| err | output | 1 | Sticky poll-timeout error |
| err_pll | output | 3 | Id of the PLL whose poll timed out |

## Verification
Within one poll, a status match and the expiry of the timeout can both fall on the same sample. The bench lets its PLL model report lock exactly D cycles after the lock command is accepted. It runs the sequence once with a limit of D, where the match lands on the final allowed sample and the run must succeed, and once with a limit of D-1, where the run must stop with an error on the core PLL after nine commands. A second pairing places a new start in the middle of a run: the bench checks that the register image and the command count still reflect the first run's settings.

// File: rtl/plls_pkg.sv
package plls_pkg;
  localparam int NPLL  = 5;
  localparam int CFG_W = 27;

  localparam logic [2:0] PLL_PROC  = 3'd0;
  localparam logic [2:0] PLL_CORE  = 3'd1;
  localparam logic [2:0] PLL_PERI  = 3'd2;
  localparam logic [2:0] PLL_PERI2 = 3'd3;
  localparam logic [2:0] PLL_ACCEL = 3'd4;

  localparam logic [2:0] STG_FIRST = 3'd0;  // processor into bypass
  localparam logic [2:0] STG_LAST  = 3'd5;  // processor programmed and locked

  localparam logic [2:0] MODE_STOP     = 3'd1;
  localparam logic [2:0] MODE_LP_BYP   = 3'd5;
  localparam logic [2:0] MODE_FAST_BYP = 3'd6;
  localparam logic [2:0] MODE_LOCK     = 3'd7;

  localparam logic [31:0] MSK_MODE = 32'h0000_0007;
  localparam logic [31:0] MSK_FSEL = 32'h0000_00F0;
  localparam logic [31:0] MSK_MULT = 32'h0007_FF00;
  localparam logic [31:0] MSK_NDIV = 32'h0000_007F;
  localparam logic [31:0] MSK_POST = 32'h0000_001F;
  localparam logic [31:0] MSK_SEL  = 32'h0000_0007;
  localparam logic [31:0] MSK_PDIV = 32'h0000_00C0;
  localparam logic [31:0] MSK_DIV4 = 32'h0000_0100;

  typedef enum logic [3:0] {
    OP_IDLE, OP_SEL, OP_PREDIV, OP_CLR4, OP_MODE_OFF, OP_POLL_OFF,
    OP_M2_ERR, OP_M2, OP_M, OP_N, OP_FSEL, OP_MODE_LOCK, OP_POLL_LOCK
  } op_e;

  typedef struct packed {
    logic [3:0]  fsel;
    logic [4:0]  m2;
    logic [10:0] mult;
    logic [6:0]  ndiv;
  } pll_cfg_t;

  function automatic logic [2:0] tbl_index(input logic [2:0] sel);
    return (sel > 3'd2) ? (sel >> 1) : sel;
  endfunction

  function automatic logic [1:0] prediv_code(input logic [2:0] sel);
    return (sel > 3'd2) ? 2'd2 : 2'd1;
  endfunction

  function automatic logic [2:0] off_mode(input logic [2:0] pll);
    if (pll == PLL_PROC) return MODE_LP_BYP;
    if (pll == PLL_CORE) return MODE_FAST_BYP;
    return MODE_STOP;
  endfunction

  function automatic logic [2:0] stage_pll(input logic [2:0] stage);
    return (stage == STG_FIRST || stage >= STG_LAST) ? PLL_PROC : stage;
  endfunction
endpackage

// File: rtl/plls_cmd_gen.sv
module plls_cmd_gen
  import plls_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] SYS_BASE = 'h20
) (
  input  op_e               op,
  input  logic [2:0]        pll,
  input  pll_cfg_t          cfg,
  input  logic [2:0]        sel,
  output logic              is_write,
  output logic [ADDR_W-1:0] addr,
  output logic [31:0]       mask,
  output logic [31:0]       data
);
  logic [ADDR_W-1:0] base;
  assign base = ADDR_W'({pll, 2'b00});

  always_comb begin
    is_write = 1'b1;
    addr     = base;
    mask     = '0;
    data     = '0;
    case (op)
      OP_SEL:       begin addr = SYS_BASE; mask = MSK_SEL; data = {29'd0, sel}; end
      OP_PREDIV:    begin addr = SYS_BASE + ADDR_W'(1); mask = MSK_PDIV;
                          data = {24'd0, prediv_code(sel), 6'd0}; end
      OP_CLR4:      begin addr = SYS_BASE + ADDR_W'(1); mask = MSK_DIV4; data = '0; end
      OP_MODE_OFF:  begin mask = MSK_MODE; data = {29'd0, off_mode(pll)}; end
      OP_M2_ERR:    begin addr = base + ADDR_W'(2); mask = MSK_POST;
                          data = {27'd0, cfg.m2 + 5'd1}; end
      OP_M2:        begin addr = base + ADDR_W'(2); mask = MSK_POST; data = {27'd0, cfg.m2}; end
      OP_M:         begin addr = base + ADDR_W'(1); mask = MSK_MULT;
                          data = {13'd0, cfg.mult, 8'd0}; end
      OP_N:         begin addr = base + ADDR_W'(1); mask = MSK_NDIV; data = {25'd0, cfg.ndiv}; end
      OP_FSEL:      begin mask = MSK_FSEL; data = {24'd0, cfg.fsel, 4'd0}; end
      OP_MODE_LOCK: begin mask = MSK_MODE; data = {29'd0, MODE_LOCK}; end
      default:      is_write = 1'b0;
    endcase
  end
endmodule

// File: rtl/plls_poll.sv
module plls_poll
  import plls_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              want_lock,
  input  logic [2:0]        pll,
  input  logic [2*NPLL-1:0] stat,
  input  logic [TMO_W-1:0]  limit,
  output logic              hit,
  output logic              expired
);
  logic [1:0]       st;
  logic [TMO_W-1:0] cnt_q;
  logic             is_peri, locked, idle;

  always_comb begin
    st = '0;
    for (int i = 0; i < NPLL; i++)
      if (pll == 3'(i)) st = stat[2*i +: 2];
  end

  assign is_peri = (pll == PLL_PERI);
  assign locked  = is_peri ? (st == 2'b10) : st[0];
  assign idle    = is_peri ? (st == 2'b00) : !st[0];
  assign hit     = active && (want_lock ? locked : idle);
  assign expired = active && !hit && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!active || hit)   cnt_q <= '0;
    else if (!expired)         cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active && $stable(limit) |-> cnt_q <= limit); // R8
endmodule

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq
  import plls_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] SYS_BASE = 'h20,
  parameter int                TMO_W    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [2:0]            sel_code,
  input  logic                  newer_family,
  input  logic                  errata_si,
  input  logic                  has_accel,
  input  logic [TMO_W-1:0]      poll_limit,
  input  logic [NPLL*CFG_W-1:0] pll_cfg,
  input  logic [2*NPLL-1:0]     pll_stat,
  output logic [2:0]            tbl_idx,
  output logic                  cmd_valid,
  input  logic                  cmd_ready,
  output logic [ADDR_W-1:0]     cmd_addr,
  output logic [31:0]           cmd_mask,
  output logic [31:0]           cmd_data,
  output logic                  busy,
  output logic                  done,
  output logic                  err,
  output logic [2:0]            err_pll
);
  op_e        op_q, op_d, prog_op;
  logic [2:0] stage_q, stage_d, sel_q, pll_id, err_pll_q;
  logic       newer_q, errata_q, accel_q, done_q, err_q;
  logic       is_write, polling, want_lock, hit, expired, step, start_go;
  pll_cfg_t   cur_cfg;

  assign pll_id    = stage_pll(stage_q);
  assign busy      = (op_q != OP_IDLE);
  assign polling   = (op_q == OP_POLL_OFF) || (op_q == OP_POLL_LOCK);
  assign want_lock = (op_q == OP_POLL_LOCK);
  assign start_go  = start && !busy;
  assign step      = is_write ? cmd_ready : hit;
  assign tbl_idx   = tbl_index(sel_q);
  assign done      = done_q;
  assign err       = err_q;
  assign err_pll   = err_pll_q;

  always_comb begin
    cur_cfg = '0;
    for (int i = 0; i < NPLL; i++)
      if (pll_id == 3'(i)) cur_cfg = pll_cfg[i*CFG_W +: CFG_W];
  end

  plls_cmd_gen #(.ADDR_W(ADDR_W), .SYS_BASE(SYS_BASE)) u_cmd (
    .op(op_q), .pll(pll_id), .cfg(cur_cfg), .sel(sel_q),
    .is_write(is_write), .addr(cmd_addr), .mask(cmd_mask), .data(cmd_data));

  plls_poll #(.TMO_W(TMO_W)) u_poll (
    .clk(clk), .rst_n(rst_n), .active(polling), .want_lock(want_lock),
    .pll(pll_id), .stat(pll_stat), .limit(poll_limit),
    .hit(hit), .expired(expired));

  assign cmd_valid = busy && is_write;

  always_comb begin
    op_d    = op_q;
    stage_d = stage_q;
    prog_op = errata_q ? OP_M2_ERR : OP_M2;
    case (op_q)
      OP_SEL:       op_d = OP_PREDIV;
      OP_PREDIV:    op_d = (newer_q && sel_q != 3'd1) ? OP_CLR4 : OP_MODE_OFF;
      OP_CLR4:      op_d = OP_MODE_OFF;
      OP_MODE_OFF:  op_d = OP_POLL_OFF;
      OP_POLL_OFF:
        if (stage_q == STG_FIRST) begin
          stage_d = PLL_CORE;
          op_d    = OP_MODE_OFF;
        end else begin
          op_d = prog_op;
        end
      OP_M2_ERR:    op_d = OP_M2;
      OP_M2:        op_d = OP_M;
      OP_M:         op_d = OP_N;
      OP_N:         op_d = OP_FSEL;
      OP_FSEL:      op_d = OP_MODE_LOCK;
      OP_MODE_LOCK: op_d = OP_POLL_LOCK;
      OP_POLL_LOCK:
        if (stage_q == STG_LAST) begin
          op_d = OP_IDLE;
        end else begin
          stage_d = (stage_q == PLL_PERI2 && !accel_q) ? STG_LAST : stage_q + 3'd1;
          op_d    = (stage_d == STG_LAST) ? prog_op : OP_MODE_OFF;
        end
      default:      op_d = op_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q <= OP_IDLE;  stage_q <= STG_FIRST;  sel_q <= '0;
      newer_q <= 1'b0;  errata_q <= 1'b0;  accel_q <= 1'b0;
      done_q <= 1'b0;   err_q <= 1'b0;     err_pll_q <= '0;
    end else if (start_go) begin
      op_q <= OP_SEL;   stage_q <= STG_FIRST;  sel_q <= sel_code;
      newer_q <= newer_family;  errata_q <= errata_si;  accel_q <= has_accel;
      done_q <= 1'b0;   err_q <= 1'b0;     err_pll_q <= '0;
    end else if (busy) begin
      if (expired) begin
        op_q <= OP_IDLE;  err_q <= 1'b1;  err_pll_q <= pll_id;  done_q <= 1'b1;
      end else if (step) begin
        op_q    <= op_d;
        stage_q <= stage_d;
        if (op_d == OP_IDLE) done_q <= 1'b1;
      end
    end
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_mask) && $stable(cmd_data)); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err && !start |=> err); // R8
  AST_ERR_FROM_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(polling)); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R11
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> op_q != OP_SEL); // R11
  AST_PROC_LOCK_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_addr == '0 && cmd_mask == MSK_MODE && cmd_data[2:0] == MODE_LOCK
      |-> stage_q == STG_LAST); // R3
endmodule

// File: tb/sim_pll_bringup_seq.sv
module sim_pll_bringup_seq;
  import plls_pkg::*;

  localparam int CLK_PER = 10;
  localparam int NVEC    = 6;
  // {sel[2:0], newer, errata, accel, exp_idx[2:0], exp_pdiv[1:0], exp_bit8}
  localparam logic [11:0] VEC [NVEC] = '{
    {3'd0, 1'b0, 1'b0, 1'b1, 3'd0, 2'd1, 1'b1},
    {3'd1, 1'b1, 1'b0, 1'b1, 3'd1, 2'd1, 1'b1},
    {3'd3, 1'b1, 1'b1, 1'b0, 3'd1, 2'd2, 1'b0},
    {3'd4, 1'b0, 1'b1, 1'b1, 3'd2, 2'd2, 1'b1},
    {3'd2, 1'b1, 1'b0, 1'b1, 3'd2, 2'd1, 1'b0},
    {3'd7, 1'b0, 1'b0, 1'b0, 3'd3, 2'd2, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0] sel_code = '0;
  logic newer = 1'b0, errata = 1'b0, accel = 1'b1;
  logic [15:0] limit = 16'd20;
  logic [NPLL*CFG_W-1:0] cfg;
  logic [2*NPLL-1:0] stat;
  logic [2:0] tbl_idx, err_pll;
  logic cmd_valid, cmd_ready, busy, done, err;
  logic [7:0] cmd_addr;
  logic [31:0] cmd_mask, cmd_data;

  logic [31:0] rf [64];
  logic [1:0]  st [NPLL];
  int          cd [NPLL];
  logic        preset = 1'b0, stall_en = 1'b0, tog = 1'b0, wrong_code = 1'b0;
  int          dly = 2;
  int          nwr, nlock, pm2_cnt, pi;
  logic [14:0] lseq;
  logic [4:0]  pm2_first;
  int          nchk = 0, nerr = 0, cyc = 0;

  always #(CLK_PER/2) clk = ~clk;

  function automatic logic [3:0]  b_fsel(int p); return 4'(p + 4); endfunction
  function automatic logic [4:0]  b_m2(int p);   return 5'(p + 1); endfunction
  function automatic logic [10:0] b_mult(int p); return 11'(200 + 17*p); endfunction
  function automatic logic [6:0]  b_ndiv(int p); return 7'(p + 3); endfunction

  always_comb begin
    for (int p = 0; p < NPLL; p++) begin
      cfg[p*CFG_W +: CFG_W] = {b_fsel(p), b_m2(p), b_mult(p), b_ndiv(p)};
      stat[2*p +: 2] = st[p];
    end
  end

  assign cmd_ready = stall_en ? tog : 1'b1;

  pll_bringup_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .sel_code(sel_code),
    .newer_family(newer), .errata_si(errata), .has_accel(accel),
    .poll_limit(limit), .pll_cfg(cfg), .pll_stat(stat), .tbl_idx(tbl_idx),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_mask(cmd_mask), .cmd_data(cmd_data), .busy(busy), .done(done),
    .err(err), .err_pll(err_pll));

  // register file and PLL status model
  always @(posedge clk) begin
    tog <= ~tog;
    cyc <= cyc + 1;
    if (preset) begin
      for (int i = 0; i < 64; i++) rf[i] <= (i == 33) ? 32'h100 : 32'h0;
      for (int p = 0; p < NPLL; p++) begin st[p] <= 2'b00; cd[p] <= 0; end
      nwr <= 0; nlock <= 0; pm2_cnt <= 0; lseq <= '0; pm2_first <= '0;
    end else begin
      for (int p = 0; p < NPLL; p++) begin
        if (cd[p] > 1) cd[p] <= cd[p] - 1;
        else if (cd[p] == 1) begin
          cd[p] <= 0;
          st[p] <= (p == 2 && !wrong_code) ? 2'b10 : 2'b01;
        end
      end
      if (cmd_valid && cmd_ready) begin
        rf[cmd_addr[5:0]] <= (rf[cmd_addr[5:0]] & ~cmd_mask) | (cmd_data & cmd_mask);
        nwr <= nwr + 1;
        if (cmd_addr < 8'd20 && cmd_addr[1:0] == 2'b00 && cmd_mask == 32'h7) begin
          pi = int'(cmd_addr[4:2]);
          if (cmd_data[2:0] == 3'd7) begin
            cd[pi] <= dly;
            lseq <= {lseq[11:0], 3'(pi)};
            nlock <= nlock + 1;
          end else begin
            cd[pi] <= 0;
            st[pi] <= 2'b00;
          end
        end
        if (cmd_addr == 8'd10) begin
          pm2_cnt <= pm2_cnt + 1;
          if (pm2_cnt == 0) pm2_first <= cmd_data[4:0];
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_writes(logic [2:0] s, logic nw, logic er, logic ac);
    return 3 + ((nw && s != 3'd1) ? 1 : 0) + (ac ? 4 : 3) * (6 + int'(er)) + 5 + int'(er);
  endfunction

  task automatic run(input logic [2:0] s, input logic nw, er, ac, input int lim, d,
                     input logic stl, wc, input int restart_at);
    @(negedge clk);
    sel_code = s; newer = nw; errata = er; accel = ac; limit = 16'(lim);
    dly = d; stall_en = stl; wrong_code = wc; preset = 1'b1;
    @(negedge clk);
    preset = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 3000 && !done; k++) begin
      if (k == restart_at) begin start = 1'b1; sel_code = 3'd4; end
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk("R11 done reached", {31'd0, done}, 32'd1);
  endtask

  task automatic check_ok(input logic [2:0] s, input logic nw, er, ac,
                          input logic [2:0] ei, input logic [1:0] ep, input logic eb);
    logic [31:0] m2e;
    chk("R11 busy low at done", {31'd0, busy}, 32'd0);
    chk("R8 no error", {31'd0, err}, 32'd0);
    chk("R1 tbl_idx", {29'd0, tbl_idx}, {29'd0, ei});
    chk("R1 prediv field", {30'd0, rf[33][7:6]}, {30'd0, ep});
    chk("R1 select field", {29'd0, rf[32][2:0]}, {29'd0, s});
    chk("R2 bit8", {31'd0, rf[33][8]}, {31'd0, eb});
    chk("R4 write count", 32'(nwr), 32'(exp_writes(s, nw, er, ac)));
    chk("R4 lock order", {17'd0, lseq},
        ac ? {17'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd0} : {17'd0, 3'd0, 3'd1, 3'd2, 3'd3, 3'd0});
    chk("R3 lock count", 32'(nlock), ac ? 32'd5 : 32'd4);
    chk("R3 proc mode locked", {29'd0, rf[0][2:0]}, 32'd7);
    chk("R5 core mode/fsel", rf[4], {24'd0, b_fsel(1), 4'd7});
    chk("R5 core mult/ndiv", rf[5], {13'd0, b_mult(1), 1'b0, b_ndiv(1)});
    chk("R5 peri post", rf[10], {27'd0, b_m2(2)});
    chk("R5 proc mult/ndiv", rf[1], {13'd0, b_mult(0), 1'b0, b_ndiv(0)});
    chk("R6 peri post writes", 32'(pm2_cnt), er ? 32'd2 : 32'd1);
    m2e = er ? {27'd0, b_m2(2) + 5'd1} : {27'd0, b_m2(2)};
    chk("R6 first post value", {27'd0, pm2_first}, m2e);
    if (!ac) chk("R4 accel untouched", rf[16] | rf[17] | rf[18], 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset busy", {31'd0, busy}, 32'd0);
    chk("R11 reset done", {31'd0, done}, 32'd0);
    chk("R8 reset err", {31'd0, err}, 32'd0);
    chk("R10 reset cmd_valid", {31'd0, cmd_valid}, 32'd0);
    rst_n = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      run(VEC[v][11:9], VEC[v][8], VEC[v][7], VEC[v][6], 20, 2, 1'b0, 1'b0, -1);
      check_ok(VEC[v][11:9], VEC[v][8], VEC[v][7], VEC[v][6], VEC[v][5:3], VEC[v][2:1], VEC[v][0]);
    end

    // R9: lock on the final allowed sample (limit == delay) succeeds
    run(3'd0, 1'b0, 1'b0, 1'b1, 3, 3, 1'b0, 1'b0, -1);
    chk("R9 match on last sample", {31'd0, err}, 32'd0);
    chk("R9 full run writes", 32'(nwr), 32'd32);

    // R8: one sample short times out on the core PLL
    run(3'd0, 1'b0, 1'b0, 1'b1, 2, 3, 1'b0, 1'b0, -1);
    chk("R8 timeout err", {31'd0, err}, 32'd1);
    chk("R8 timeout pll", {29'd0, err_pll}, 32'd1);
    chk("R8 commands stop", 32'(nwr), 32'd9);
    chk("R3 proc still bypass", {29'd0, rf[0][2:0]}, 32'd5);
    repeat (4) @(negedge clk);
    chk("R8 err sticky", {31'd0, err}, 32'd1);

    // R7: peripheral reporting 1 is not lock
    run(3'd0, 1'b0, 1'b0, 1'b1, 10, 2, 1'b0, 1'b1, -1);
    chk("R7 peri code 1 rejected", {31'd0, err}, 32'd1);
    chk("R7 peri named", {29'd0, err_pll}, 32'd2);

    // R10: stalled handshake gives the same result
    run(3'd0, 1'b0, 1'b0, 1'b1, 20, 2, 1'b1, 1'b0, -1);
    check_ok(3'd0, 1'b0, 1'b0, 1'b1, 3'd0, 2'd1, 1'b1);

    // R11: start while busy is ignored
    run(3'd0, 1'b0, 1'b0, 1'b1, 20, 2, 1'b0, 1'b0, 15);
    chk("R11 restart ignored sel", {29'd0, rf[32][2:0]}, 32'd0);
    chk("R11 restart ignored writes", 32'(nwr), 32'd32);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    nerr++; nchk++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule